// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns control pin activity into the 6-bit word that sets a 64-state step attenuator. Each step is 0.5 dB. The bit weights, from MSB to LSB, are 16, 8, 4, 2, 1 and 0.5 dB. A code of all zeros means reference loss, and all ones means 31.5 dB.

A mode pin chooses between two ways of loading the word:

- **Parallel control:** six control pins supply the word.
- **Serial control:** a data/clock pair fills a shift register.

In both modes a transparent latch sits between the source and the output, and the latch-enable pin drives it:

- While latch enable is high the latch is open. In parallel mode this means the output follows the control pins directly.
- When latch enable falls, the latch holds the last value it passed.

All pins are sampled in the `clk` domain. The serial clock is edge-detected against its value in the previous cycle, so all control pins must already be synchronous to `clk`.

Power-up is modelled as the first clock cycle after the active-low reset is released. In that cycle the output takes a defined preset word:

- **Serial mode:** the preset is the six parallel pins.
- **Parallel mode, latch enable low:** the preset comes from a four-entry table indexed by two select pins.
- **Parallel mode, latch enable high:** the preset is the parallel pins, and the select pins are ignored.

The preset stays in place until the latch next opens. A serial output carries the shift register MSB, so several devices can be chained on one data line.

Top module: `atten_ctrl_top`

## Requirements
- R1: While `rst_n` is low, `atten_word` is 0 and `ser_out` is 0.
- R2: In the first cycle after reset release with `ser_mode`=1, `atten_word` takes the value of `par_word`.
- R3: In the first cycle after reset release with `ser_mode`=0 and `latch_en`=0, `atten_word` is set from `preset_sel`:
  - 2'b00 gives 6'b000000 (0 dB).
  - 2'b10 gives 6'b010000 (8 dB).
  - 2'b01 gives 6'b100000 (16 dB).
  - 2'b11 gives 6'b111111 (31.5 dB).
- R4: In the first cycle after reset release with `ser_mode`=0 and `latch_en`=1, `atten_word` takes `par_word`, and `preset_sel` has no effect.
- R5: After power-up, while `latch_en` stays low, the preset word is held and `par_word` changes do not reach `atten_word`.
- R6: A rising edge of `ser_clk` shifts `ser_data` into bit 0 of the shift register and moves every bit one place toward the MSB, whatever the level of `latch_en`. The first bit shifted ends in bit 5 (16 dB) after six edges.
- R7: In serial mode with `latch_en`=1, `atten_word` equals the shift register contents, including the effect of a shift in the same cycle.
- R8: In serial mode with `latch_en`=0, `atten_word` holds while bits are shifted in.
- R9: In parallel mode with `latch_en`=1, `atten_word` equals the `par_word` sampled at the previous clock edge (direct mode).
- R10: In parallel mode, a fall of `latch_en` keeps the word present during the last high cycle, and later `par_word` changes are ignored.
- R11: `ser_out` is the shift register MSB, so the six edges that load a new word present the previous word on `ser_out` MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_mode | input | 1 | 0 selects parallel control, 1 selects serial control |
| latch_en | input | 1 | Latch open when high, holding when low |
| par_word | input | 6 | Parallel control word, MSB is 16 dB |
| preset_sel | input | 2 | Power-up table index used in parallel mode |
| ser_clk | input | 1 | Serial shift clock, acts on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| atten_word | output | 6 | Attenuation word to the RF switches |
| ser_out | output | 1 | Shift register MSB for chaining |

## Verification
The assertions check these rules on every clock cycle:

- The output holds while the latch is closed.
- The output tracks the parallel pins in direct mode.
- A serial bit reaches the LSB of the output in transparent serial mode.
- The serial output changes only on a serial clock edge.
- The all-ones entry of the preset table is applied.

Some behaviours can only be shown by the bench's scenarios:

- The other preset table entries.
- MSB-first bit ordering across six shifts.
- The previous word appearing on the chain output.
- The preset surviving until the latch first opens.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'b00,
    SRC_PRESET = 2'b01,
    SRC_LIVE   = 2'b10
  } word_src_e;
endpackage

// File: rtl/atten_shift.sv
module atten_shift #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_data,
  output logic [W-1:0] sr_next,
  output logic         ser_out
);
  logic         sclk_q;
  logic [W-1:0] sr_q;
  logic         shift_en;

  always_comb begin
    shift_en = ser_clk & ~sclk_q;
    sr_next  = sr_q;
    if (shift_en) begin
      sr_next = {sr_q[W-2:0], ser_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_q <= ser_clk;
      if (shift_en) begin
        sr_q <= sr_next;
      end
    end
  end

  assign ser_out = sr_q[W-1];
endmodule

// File: rtl/atten_preset.sv
module atten_preset #(
  parameter int W = 6
) (
  input  logic         ser_mode,
  input  logic         latch_en,
  input  logic [1:0]   preset_sel,
  input  logic [W-1:0] par_word,
  output logic [W-1:0] preset_word
);
  localparam logic [W-1:0] CODE_ZERO = '0;
  localparam logic [W-1:0] CODE_MID  = W'(1) << (W - 2);
  localparam logic [W-1:0] CODE_HIGH = W'(1) << (W - 1);
  localparam logic [W-1:0] CODE_MAX  = '1;

  logic [W-1:0] table_word;

  always_comb begin
    unique case (preset_sel)
      2'b00:   table_word = CODE_ZERO;
      2'b10:   table_word = CODE_MID;
      2'b01:   table_word = CODE_HIGH;
      default: table_word = CODE_MAX;
    endcase
  end

  always_comb begin
    if (ser_mode || latch_en) begin
      preset_word = par_word;
    end else begin
      preset_word = table_word;
    end
  end
endmodule

// File: rtl/atten_hold.sv
module atten_hold #(
  parameter int W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 latch_en,
  input  logic [W-1:0]         live_word,
  input  logic [W-1:0]         preset_word,
  output logic [W-1:0]         atten_word
);
  import atten_pkg::*;

  logic         init_done_q;
  word_src_e    src;
  logic [W-1:0] word_d;
  logic [W-1:0] word_q;
  logic         word_en;

  always_comb begin
    if (!init_done_q) begin
      src = SRC_PRESET;
    end else if (latch_en) begin
      src = SRC_LIVE;
    end else begin
      src = SRC_HOLD;
    end
  end

  always_comb begin
    word_en = 1'b1;
    word_d  = word_q;
    unique case (src)
      SRC_PRESET: word_d = preset_word;
      SRC_LIVE:   word_d = live_word;
      default:    word_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done_q <= 1'b0;
      word_q      <= '0;
    end else begin
      init_done_q <= 1'b1;
      if (word_en) begin
        word_q <= word_d;
      end
    end
  end

  assign atten_word = word_q;
endmodule

// File: rtl/atten_ctrl_top.sv
module atten_ctrl_top #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_mode,
  input  logic         latch_en,
  input  logic [W-1:0] par_word,
  input  logic [1:0]   preset_sel,
  input  logic         ser_clk,
  input  logic         ser_data,
  output logic [W-1:0] atten_word,
  output logic         ser_out
);
  logic [W-1:0] sr_next;
  logic [W-1:0] preset_word;
  logic [W-1:0] live_word;

  atten_shift #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .sr_next  (sr_next),
    .ser_out  (ser_out)
  );

  atten_preset #(.W(W)) u_preset (
    .ser_mode    (ser_mode),
    .latch_en    (latch_en),
    .preset_sel  (preset_sel),
    .par_word    (par_word),
    .preset_word (preset_word)
  );

  assign live_word = ser_mode ? sr_next : par_word;

  atten_hold #(.W(W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_en    (latch_en),
    .live_word   (live_word),
    .preset_word (preset_word),
    .atten_word  (atten_word)
  );
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_mode,
  input logic         latch_en,
  input logic [W-1:0] par_word,
  input logic [1:0]   preset_sel,
  input logic         ser_clk,
  input logic         ser_data,
  input logic [W-1:0] atten_word,
  input logic         ser_out
);
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
    end else begin
      started <= 1'b1;
    end
  end

  AST_PRESET_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && !ser_mode && !latch_en && preset_sel == 2'b11) |=> (atten_word == '1)); // R3

  AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !latch_en) |=> $stable(atten_word)); // R5

  AST_SOUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$rose(ser_clk)) |=> $stable(ser_out)); // R6

  AST_SER_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (started && ser_mode && latch_en && $rose(ser_clk)) |=> (atten_word[0] == $past(ser_data))); // R7

  AST_DIRECT_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !ser_mode && latch_en) |=> (atten_word == $past(par_word))); // R9
endmodule

bind atten_ctrl_top atten_ctrl_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_mode   (ser_mode),
  .latch_en   (latch_en),
  .par_word   (par_word),
  .preset_sel (preset_sel),
  .ser_clk    (ser_clk),
  .ser_data   (ser_data),
  .atten_word (atten_word),
  .ser_out    (ser_out)
);

// File: tb/atten_ctrl_top_test.sv
module atten_ctrl_top_test;
  localparam int W = 6;

  logic         clk;
  logic         rst_n;
  logic         ser_mode;
  logic         latch_en;
  logic [W-1:0] par_word;
  logic [1:0]   preset_sel;
  logic         ser_clk;
  logic         ser_data;
  logic [W-1:0] atten_word;
  logic         ser_out;

  int n_chk;
  int n_bad;
  bit done;

  atten_ctrl_top #(.W(W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_mode   (ser_mode),
    .latch_en   (latch_en),
    .par_word   (par_word),
    .preset_sel (preset_sel),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .atten_word (atten_word),
    .ser_out    (ser_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {ser_mode, latch_en, preset_sel[1:0], par_word[5:0], expected[5:0]}
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b11, 6'h2A, 6'h2A},   // R2
    {1'b1, 1'b1, 2'b01, 6'h15, 6'h15},   // R2
    {1'b0, 1'b0, 2'b00, 6'h3F, 6'h00},   // R3
    {1'b0, 1'b0, 2'b10, 6'h3F, 6'h10},   // R3
    {1'b0, 1'b0, 2'b01, 6'h00, 6'h20},   // R3
    {1'b0, 1'b1, 2'b11, 6'h05, 6'h05},   // R4
    {1'b0, 1'b0, 2'b11, 6'h03, 6'h3F}    // R3
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    ser_data = b;
    ser_clk  = 1'b1;
    tick();
    @(negedge clk);
    ser_clk = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done = 0;
    rst_n = 1'b0;
    ser_mode = 1'b0;
    latch_en = 1'b0;
    par_word = '0;
    preset_sel = 2'b00;
    ser_clk = 1'b0;
    ser_data = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset word", atten_word, '0);
    check("R1 reset sout", {5'b0, ser_out}, '0);

    // power-up presets from the vector table (R2, R3, R4)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst_n = 1'b0;
      ser_mode   = VEC[i][15];
      latch_en   = VEC[i][14];
      preset_sel = VEC[i][13:12];
      par_word   = VEC[i][11:6];
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      check($sformatf("R2/R3/R4 preset vector %0d", i), atten_word, VEC[i][5:0]);
    end

    // R5: last vector left parallel, latch closed, word 3F; pins move
    @(negedge clk);
    par_word = 6'h03;
    repeat (3) tick();
    check("R5 preset held", atten_word, 6'h3F);

    // R9: direct parallel
    @(negedge clk);
    par_word = 6'h07;
    latch_en = 1'b1;
    tick();
    check("R9 direct first", atten_word, 6'h07);
    @(negedge clk);
    par_word = 6'h0C;
    tick();
    check("R9 direct follow", atten_word, 6'h0C);

    // R10: close latch, then change pins
    @(negedge clk);
    latch_en = 1'b0;
    tick();
    @(negedge clk);
    par_word = 6'h14;
    repeat (2) tick();
    check("R10 latched hold", atten_word, 6'h0C);

    // R8: serial shifting with latch closed keeps output
    @(negedge clk);
    ser_mode = 1'b1;
    for (int b = W - 1; b >= 0; b--) shift_bit(1'(6'b101101 >> b));
    tick();
    check("R8 serial hold", atten_word, 6'h0C);
    check("R11 sout is msb", {5'b0, ser_out}, 6'h01);

    // R7 / R6: open latch, register shows shifted word MSB-first
    @(negedge clk);
    latch_en = 1'b1;
    tick();
    check("R6 R7 shifted word", atten_word, 6'b101101);

    // R7: shift while transparent
    shift_bit(1'b0);
    check("R7 transparent shift", atten_word, 6'b011010);
    check("R6 sout after shift", {5'b0, ser_out}, 6'h00);

    // R11: load A with latch closed, then shift B and watch A stream out
    @(negedge clk);
    latch_en = 1'b0;
    for (int b = W - 1; b >= 0; b--) shift_bit(1'(6'b110010 >> b));
    for (int b = W - 1; b >= 0; b--) begin
      check($sformatf("R11 chain bit %0d", b), {5'b0, ser_out}, {5'b0, 1'(6'b110010 >> b)});
      shift_bit(1'(6'b000111 >> b));
    end
    check("R8 hold during chain", atten_word, 6'b011010);
    @(negedge clk);
    latch_en = 1'b1;
    tick();
    check("R6 second word", atten_word, 6'b000111);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", atten_word, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule